// File: doc/BRIEF.md
# Exception Entry Stack Sequencer

This block carries out the memory side of entering an exception once a vector has been granted. On a start pulse it takes the current status, program counter, stack pointer and the opcode being executed, and computes the new status word. It then writes a stack frame one 16-bit word at a time through a request/acknowledge memory port and reads the new program counter as a long from the vector table. The `FRAME_EXT` parameter chooses between a compact frame and an extended frame. The extended frame carries a vector-offset word, and for the two fault vectors it pads the frame to seventeen words.

The same engine also runs the power-up sequence. No frame is written. The stack pointer and program counter are read as longs from the first eight bytes of memory, and the status is forced to supervisor mode with every interrupt level masked. A fault reported by memory on any access stops the sequence and is reported to the arbiter as an access error. A completed sequence ends with a one-cycle done pulse, and the final program counter, stack pointer and status are held on the outputs.

Top module: `exc_entry_seq`

## Requirements
- R1: On completion of a vector entry, `sr_o` equals `sr_i` with bit 15 (trace) cleared and bit 13 (supervisor) set. For interrupt vectors 25..31 and 57..63, bits 10:8 (mask) are also replaced by `vec_i[2:0]`. No other vector changes the mask.
- R2: With `FRAME_EXT=0` and a vector other than 2 or 3, the frame occupies 3 words. Read from the new stack pointer upward they are: saved status, PC[31:16], PC[15:0].
- R3: With `FRAME_EXT=0` and vector 2 or 3, the frame occupies 7 words. Read upward they are: 0, 0, 0, opcode, saved status, PC[31:16], PC[15:0].
- R4: With `FRAME_EXT=1` and a vector other than 2 or 3, the frame occupies 4 words. Read upward they are: saved status, PC[31:16], PC[15:0], vector×4.
- R5: With `FRAME_EXT=1` and vector 2 or 3, the frame occupies 17 words. Read upward they are: saved status, PC[31:16], PC[15:0], 0xF000|(vector×4), ten zero words, opcode, opcode, 0.
- R6: Frame words are written one at a time at strictly descending addresses, each 2 below the previous, and the first one lands at `sp_i`−2. The high half of every long ends up at the lower address. `sp_o` equals `sp_i` − 2×(frame words).
- R7: After the frame, the block reads the word at vector×4 as PC[31:16] and the word at vector×4+2 as PC[15:0], and presents the result on `pc_o`.
- R8: With `reset_seq_i` high at start, no write occurs. `sp_o` is the long read from address 0 and `pc_o` the long read from address 4, each high word first. `sr_o` is `sr_i` with bit 15 cleared, bit 13 set and bits 10:8 = 7. `clr_stop_o` pulses together with `done_o`.
- R9: A `mem_fault_i` answering any write or read ends the sequence. `acc_err_o` pulses for one cycle, `done_o` does not pulse, no further access is issued, and `busy_o` is low while `acc_err_o` is high.
- R10: `done_o` is a single-cycle pulse that never coincides with `acc_err_o`. After reset, `busy_o`, `done_o` and `mem_req_o` are low.
- R11: `start_i` is ignored while `busy_o` is high. The running sequence produces the same frame and outputs as without the extra pulse.
- R12: Once raised, `mem_req_o` keeps address, direction and write data unchanged until `mem_ack_i` or `mem_fault_i` answers it. No request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a sequence (taken only while idle) |
| reset_seq_i | input | 1 | With start: run the power-up load instead of a vector entry |
| vec_i | input | 8 | Granted vector number |
| sr_i | input | 16 | Current status register |
| pc_i | input | 32 | Current program counter |
| sp_i | input | 32 | Current supervisor stack pointer |
| opcode_i | input | 16 | Opcode word of the current instruction |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access completed |
| mem_fault_i | input | 1 | Access failed |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| acc_err_o | output | 1 | One-cycle access-error pulse |
| clr_stop_o | output | 1 | Release the stopped state (power-up sequence only) |
| pc_o | output | 32 | New program counter |
| sp_o | output | 32 | New stack pointer |
| sr_o | output | 16 | New status register |

## Verification
Two instances, one per frame format, receive the same stimulus while every vector from 2 to 63 plus 64, 128 and 255 is swept. Each vector has its own table entry, PC, opcode and a status value whose old mask differs from the vector's low bits. The sweep separates fault vectors from plain ones, interrupt vectors from non-interrupts (24 and 56..64 sit on the edges), and the two frame layouts. The power-up load runs from a distinct memory image. Faults are injected on a frame write and on the vector fetch. A second start issued mid-sequence shows that the running frame is unaffected.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_READ = 2'd2,
    ST_DONE = 2'd3
  } exc_state_t;

  localparam int VEC_W  = 8;
  localparam int WORD_W = 16;
  localparam int LONG_W = 32;
  localparam int IDX_W  = 5;   // enough for the 17-word padded frame

  // Interrupt vectors: external levels 25..31, on-chip levels 57..63
  function automatic logic is_irq_vec(input logic [VEC_W-1:0] v);
    return ((v >= 8'd25) && (v <= 8'd31)) || ((v >= 8'd57) && (v <= 8'd63));
  endfunction

  // Vectors that carry the long fault frame
  function automatic logic is_fault_vec(input logic [VEC_W-1:0] v);
    return (v == 8'd2) || (v == 8'd3);
  endfunction

  function automatic logic [WORD_W-1:0] vec_offset(input logic [VEC_W-1:0] v);
    return {6'd0, v, 2'b00};
  endfunction

  function automatic logic [IDX_W-1:0] frame_words(input logic ext, input logic flt);
    if (ext) return flt ? IDX_W'(17) : IDX_W'(4);
    else     return flt ? IDX_W'(7)  : IDX_W'(3);
  endfunction

endpackage

// File: rtl/exc_frame_gen.sv
module exc_frame_gen
  import exc_pkg::*;
#(
  parameter bit EXT = 1'b1
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [VEC_W-1:0]  vec,
  input  logic [LONG_W-1:0] pc,
  input  logic [WORD_W-1:0] sr,
  input  logic [WORD_W-1:0] opc,
  output logic [WORD_W-1:0] word,
  output logic [IDX_W-1:0]  len
);
  logic flt;
  assign flt = is_fault_vec(vec);
  assign len = frame_words(EXT, flt);

  // idx is the push order: idx 0 lands at the highest address
  generate
    if (EXT) begin : g_ext
      always_comb begin
        word = '0;
        if (flt) begin
          case (idx)
            5'd1, 5'd2: word = opc;
            5'd13:      word = 16'hF000 | vec_offset(vec);
            5'd14:      word = pc[15:0];
            5'd15:      word = pc[31:16];
            5'd16:      word = sr;
            default:    word = '0;
          endcase
        end else begin
          case (idx)
            5'd0:    word = vec_offset(vec);
            5'd1:    word = pc[15:0];
            5'd2:    word = pc[31:16];
            5'd3:    word = sr;
            default: word = '0;
          endcase
        end
      end
    end else begin : g_basic
      always_comb begin
        case (idx)
          5'd0:    word = pc[15:0];
          5'd1:    word = pc[31:16];
          5'd2:    word = sr;
          5'd3:    word = flt ? opc : '0;
          default: word = '0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update
  import exc_pkg::*;
(
  input  logic [WORD_W-1:0] sr_in,
  input  logic [VEC_W-1:0]  vec,
  input  logic              pwr_up,
  output logic [WORD_W-1:0] sr_out
);
  always_comb begin
    sr_out     = sr_in;
    sr_out[15] = 1'b0;   // trace off
    sr_out[13] = 1'b1;   // supervisor on
    if (pwr_up)               sr_out[10:8] = 3'd7;
    else if (is_irq_vec(vec)) sr_out[10:8] = vec[2:0];
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter bit FRAME_EXT = 1'b1,
  parameter int AW        = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              reset_seq_i,
  input  logic [7:0]        vec_i,
  input  logic [15:0]       sr_i,
  input  logic [31:0]       pc_i,
  input  logic [31:0]       sp_i,
  input  logic [15:0]       opcode_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              mem_fault_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              acc_err_o,
  output logic              clr_stop_o,
  output logic [31:0]       pc_o,
  output logic [31:0]       sp_o,
  output logic [15:0]       sr_o
);
  localparam logic [IDX_W-1:0] LAST_RD_PWR = IDX_W'(3);
  localparam logic [IDX_W-1:0] LAST_RD_VEC = IDX_W'(1);

  exc_state_t        st;
  logic [IDX_W-1:0]  idx;
  logic [LONG_W-1:0] sp_r, pc_r;
  logic [WORD_W-1:0] sr_old_r, sr_new_r, opc_r;
  logic [VEC_W-1:0]  vec_r;
  logic              pwr_r, err_q;

  logic [WORD_W-1:0] frame_word, sr_next;
  logic [IDX_W-1:0]  frame_len;
  logic [AW-1:0]     rd_base;

  // Named internal events used by the checker
  logic acc_ok, acc_bad, push_fire, read_fire, push_last, read_last;

  exc_frame_gen #(.EXT(FRAME_EXT)) u_frame (
    .idx (idx), .vec (vec_r), .pc (pc_r), .sr (sr_old_r), .opc (opc_r),
    .word(frame_word), .len(frame_len)
  );

  exc_sr_update u_sr (
    .sr_in(sr_i), .vec(vec_i), .pwr_up(reset_seq_i), .sr_out(sr_next)
  );

  assign mem_req_o   = (st == ST_PUSH) || (st == ST_READ);
  assign mem_we_o    = (st == ST_PUSH);
  assign rd_base     = pwr_r ? '0 : {{(AW-VEC_W-2){1'b0}}, vec_r, 2'b00};
  assign mem_addr_o  = mem_we_o ? (sp_r[AW-1:0] - AW'(2))
                                : (rd_base + {{(AW-IDX_W-1){1'b0}}, idx, 1'b0});
  assign mem_wdata_o = mem_we_o ? frame_word : '0;

  assign acc_ok    = mem_req_o && mem_ack_i && !mem_fault_i;
  assign acc_bad   = mem_req_o && mem_fault_i;
  assign push_fire = acc_ok && mem_we_o;
  assign read_fire = acc_ok && !mem_we_o;
  assign push_last = push_fire && (idx == frame_len - IDX_W'(1));
  assign read_last = read_fire && (idx == (pwr_r ? LAST_RD_PWR : LAST_RD_VEC));

  assign busy_o     = (st != ST_IDLE);
  assign done_o     = (st == ST_DONE);
  assign clr_stop_o = done_o && pwr_r;
  assign acc_err_o  = err_q;
  assign pc_o       = pc_r;
  assign sp_o       = sp_r;
  assign sr_o       = sr_new_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      sp_r     <= '0;
      pc_r     <= '0;
      sr_old_r <= '0;
      sr_new_r <= '0;
      opc_r    <= '0;
      vec_r    <= '0;
      pwr_r    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            st       <= reset_seq_i ? ST_READ : ST_PUSH;
            idx      <= '0;
            pwr_r    <= reset_seq_i;
            vec_r    <= vec_i;
            sp_r     <= sp_i;
            pc_r     <= pc_i;
            opc_r    <= opcode_i;
            sr_old_r <= sr_i;
            sr_new_r <= sr_next;
          end
        end
        ST_PUSH: begin
          if (acc_bad) begin
            err_q <= 1'b1;
            st    <= ST_IDLE;
          end else if (push_fire) begin
            sp_r <= sp_r - 32'd2;
            if (push_last) begin
              st  <= ST_READ;
              idx <= '0;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        ST_READ: begin
          if (acc_bad) begin
            err_q <= 1'b1;
            st    <= ST_IDLE;
          end else if (read_fire) begin
            if (pwr_r) begin
              case (idx[1:0])
                2'd0: sp_r[31:16] <= mem_rdata_i;
                2'd1: sp_r[15:0]  <= mem_rdata_i;
                2'd2: pc_r[31:16] <= mem_rdata_i;
                default: pc_r[15:0] <= mem_rdata_i;
              endcase
            end else if (idx[0] == 1'b0) begin
              pc_r[31:16] <= mem_rdata_i;
            end else begin
              pc_r[15:0] <= mem_rdata_i;
            end
            if (read_last) st <= ST_DONE;
            else           idx <= idx + IDX_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [15:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          mem_fault_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          acc_err_o,
  input logic          clr_stop_o,
  input logic [15:0]   sr_o,
  input logic          push_fire
);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i && !mem_fault_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);

  p_push_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> (!(mem_req_o && mem_we_o) || (mem_addr_o == $past(mem_addr_o) - AW'(2))));

  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, acc_err_o}));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err_o |-> (!busy_o && !mem_req_o));

  p_status_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sr_o[13] && !sr_o[15]));

  p_pwr_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stop_o |-> (done_o && (sr_o[10:8] == 3'd7)));
endmodule

bind exc_entry_seq exc_entry_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .mem_fault_i(mem_fault_i), .busy_o(busy_o), .done_o(done_o),
  .acc_err_o(acc_err_o), .clr_stop_o(clr_stop_o), .sr_o(sr_o),
  .push_fire(push_fire)
);

// File: tb/sim_exc_entry_seq.sv
module sim_mem #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          clr,
  input  int            fault_at,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic          ack,
  output logic          fault,
  output int            cnt,
  output int            wn,
  output logic [AW-1:0] wfirst
);
  logic [15:0] m [0:1023];
  assign rdata = m[addr[10:1]];

  always @(posedge clk) begin
    if (clr) begin
      ack <= 1'b0; fault <= 1'b0; cnt <= 0; wn <= 0; wfirst <= '0;
    end else begin
      ack   <= 1'b0;
      fault <= 1'b0;
      if (req && !ack && !fault) begin
        if (cnt == fault_at) fault <= 1'b1;
        else                 ack   <= 1'b1;
        cnt <= cnt + 1;
      end
      if (req && we && ack && !fault) begin
        if (wn == 0) wfirst <= addr;
        m[addr[10:1]] <= wdata;
        wn <= wn + 1;
      end
    end
  end
endmodule

module sim_exc_entry_seq;
  localparam int AW = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, pwr, clr;
  logic [7:0] vec;
  logic [15:0] sr, opc;
  logic [31:0] pc, sp;
  int fa0, fa1;

  logic req0, we0, ack0, flt0, busy0, done0, err0, cs0;
  logic req1, we1, ack1, flt1, busy1, done1, err1, cs1;
  logic [AW-1:0] addr0, addr1, wf0, wf1;
  logic [15:0] wd0, wd1, rd0, rd1, sro0, sro1;
  logic [31:0] pco0, pco1, spo0, spo1;
  int cnt0, cnt1, wn0, wn1;

  int nchk = 0, nerr = 0;
  bit gd[2], ge[2], gc[2];

  exc_entry_seq #(.FRAME_EXT(1'b1), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .reset_seq_i(pwr), .vec_i(vec),
    .sr_i(sr), .pc_i(pc), .sp_i(sp), .opcode_i(opc),
    .mem_req_o(req0), .mem_we_o(we0), .mem_addr_o(addr0), .mem_wdata_o(wd0),
    .mem_rdata_i(rd0), .mem_ack_i(ack0), .mem_fault_i(flt0),
    .busy_o(busy0), .done_o(done0), .acc_err_o(err0), .clr_stop_o(cs0),
    .pc_o(pco0), .sp_o(spo0), .sr_o(sro0));

  exc_entry_seq #(.FRAME_EXT(1'b0), .AW(AW)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .reset_seq_i(pwr), .vec_i(vec),
    .sr_i(sr), .pc_i(pc), .sp_i(sp), .opcode_i(opc),
    .mem_req_o(req1), .mem_we_o(we1), .mem_addr_o(addr1), .mem_wdata_o(wd1),
    .mem_rdata_i(rd1), .mem_ack_i(ack1), .mem_fault_i(flt1),
    .busy_o(busy1), .done_o(done1), .acc_err_o(err1), .clr_stop_o(cs1),
    .pc_o(pco1), .sp_o(spo1), .sr_o(sro1));

  sim_mem #(.AW(AW)) mem0 (.clk(clk), .clr(clr), .fault_at(fa0), .req(req0), .we(we0),
    .addr(addr0), .wdata(wd0), .rdata(rd0), .ack(ack0), .fault(flt0),
    .cnt(cnt0), .wn(wn0), .wfirst(wf0));
  sim_mem #(.AW(AW)) mem1 (.clk(clk), .clr(clr), .fault_at(fa1), .req(req1), .we(we1),
    .addr(addr1), .wdata(wd1), .rdata(rd1), .ack(ack1), .fault(flt1),
    .cnt(cnt1), .wn(wn1), .wfirst(wf1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit irq_b(input int v);
    return ((v / 8 == 3) && (v != 24)) || ((v / 8 == 7) && (v != 56));
  endfunction

  function automatic logic [15:0] exp_sr(input int v, input logic [15:0] s, input bit p);
    logic [15:0] r;
    r = (s & 16'h5FFF) | 16'h2000;
    if (p)             r = r | 16'h0700;
    else if (irq_b(v)) r = (r & 16'hF8FF) | 16'((v % 8) * 256);
    return r;
  endfunction

  function automatic int nwords(input bit ext, input bit f);
    return ext ? (f ? 17 : 4) : (f ? 7 : 3);
  endfunction

  // frame word k counted from the new stack pointer upward
  function automatic logic [15:0] lay(input bit ext, input bit f, input int k, input int v,
                                      input logic [31:0] p, input logic [15:0] s,
                                      input logic [15:0] o);
    logic [15:0] vo;
    vo = 16'(v * 4);
    if (!ext && !f) return (k == 0) ? s : (k == 1) ? p[31:16] : p[15:0];
    if (!ext) begin
      if (k < 3) return 16'h0;
      return (k == 3) ? o : (k == 4) ? s : (k == 5) ? p[31:16] : p[15:0];
    end
    if (k == 0) return s;
    if (k == 1) return p[31:16];
    if (k == 2) return p[15:0];
    if (!f) return vo;
    if (k == 3) return 16'hF000 + vo;
    if (k == 14 || k == 15) return o;
    return 16'h0;
  endfunction

  function automatic logic [15:0] mrd(input int e, input int w);
    return (e == 0) ? mem0.m[w % 1024] : mem1.m[w % 1024];
  endfunction

  task automatic run(input bit p, input int v, input logic [31:0] s_p, input logic [31:0] p_c,
                     input logic [15:0] s_r, input logic [15:0] o, input int f0, input int f1,
                     input bit bump);
    bit fin;
    for (int i = 960; i < 1024; i++) begin mem0.m[i] = 16'hDEAD; mem1.m[i] = 16'hDEAD; end
    fa0 = f0; fa1 = f1;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    gd = '{0, 0}; ge = '{0, 0}; gc = '{0, 0};
    pwr = p; vec = 8'(v); sp = s_p; pc = p_c; sr = s_r; opc = o; start = 1'b1;
    fin = 1'b0;
    for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
      @(negedge clk);
      if (bump && cyc == 3) begin
        start = 1'b1; pwr = 1'b1; vec = 8'd40; sp = 32'h0000_0700;
        pc = 32'h0; sr = 16'h0; opc = 16'h0;
      end else begin
        start = 1'b0;
      end
      if (done0) begin gd[0] = 1; gc[0] = cs0; end
      if (done1) begin gd[1] = 1; gc[1] = cs1; end
      if (err0) begin ge[0] = 1; chk("R9 busy low with error (ext)", 32'(busy0), 0); end
      if (err1) begin ge[1] = 1; chk("R9 busy low with error (basic)", 32'(busy1), 0); end
      if ((gd[0] || ge[0]) && (gd[1] || ge[1]) && cyc > 4) fin = 1'b1;
    end
    if (!fin) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual 0 expected 1 (sequence completion)");
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_vec(input int v, input logic [31:0] s_p, input logic [31:0] p_c,
                           input logic [15:0] s_r, input logic [15:0] o);
    for (int e = 0; e < 2; e++) begin
      bit ext, f;
      int n;
      logic [31:0] nsp, gpc, gsp, gsr, gwf, gwn;
      string tg;
      ext = (e == 0);
      f   = (v == 2 || v == 3);
      n   = nwords(ext, f);
      nsp = s_p - 32'(2 * n);
      gpc = (e == 0) ? pco0 : pco1;
      gsp = (e == 0) ? spo0 : spo1;
      gsr = 32'((e == 0) ? sro0 : sro1);
      gwf = 32'((e == 0) ? wf0 : wf1);
      gwn = 32'((e == 0) ? wn0 : wn1);
      tg  = ext ? (f ? "R5" : "R4") : (f ? "R3" : "R2");
      chk($sformatf("R10 done pulse vec %0d fmt %0d", v, ext), 32'(gd[e]), 1);
      chk($sformatf("R9 no error vec %0d fmt %0d", v, ext), 32'(ge[e]), 0);
      chk($sformatf("R7 new pc vec %0d fmt %0d", v, ext), gpc,
          {8'hA0, 8'(v), 8'(v), 8'h5B});
      chk($sformatf("R6 new sp vec %0d fmt %0d", v, ext), gsp, nsp);
      chk($sformatf("R6 write count vec %0d fmt %0d", v, ext), gwn, 32'(n));
      chk($sformatf("R6 first write vec %0d fmt %0d", v, ext), gwf, 32'((s_p - 2) & 32'hFF_FFFF));
      chk($sformatf("R1 status vec %0d fmt %0d", v, ext), gsr, 32'(exp_sr(v, s_r, 0)));
      for (int k = 0; k < n; k++)
        chk($sformatf("%s frame word %0d vec %0d", tg, k, v),
            32'(mrd(e, int'(nsp / 2) + k)), 32'(lay(ext, f, k, v, p_c, s_r, o)));
    end
  endtask

  initial begin
    #1_500_000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; pwr = 1'b0; clr = 1'b1; vec = '0;
    sr = '0; opc = '0; pc = '0; sp = '0; fa0 = -1; fa1 = -1;
    for (int v = 0; v < 256; v++) begin
      mem0.m[2*v] = {8'hA0, 8'(v)}; mem0.m[2*v+1] = {8'(v), 8'h5B};
      mem1.m[2*v] = {8'hA0, 8'(v)}; mem1.m[2*v+1] = {8'(v), 8'h5B};
    end
    repeat (3) @(negedge clk);
    chk("R10 reset busy", 32'(busy0 | busy1), 0);
    chk("R10 reset done", 32'(done0 | done1), 0);
    chk("R10 reset req", 32'(req0 | req1), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle no request", 32'(req0 | req1), 0);

    // vector sweep on both formats
    for (int v = 2; v < 67; v++) begin
      int vv;
      logic [31:0] p_c;
      logic [15:0] s_r, o;
      vv  = (v < 64) ? v : (v == 64) ? 64 : (v == 65) ? 128 : 255;
      p_c = 32'h00C0_0001 + 32'(vv * 6);
      s_r = {1'b1, 4'b0, ~3'(vv % 8), 8'(vv)};
      o   = 16'h4E40 | 16'(vv);
      run(0, vv, 32'h0000_07F0, p_c, s_r, o, -1, -1, 0);
      check_vec(vv, 32'h0000_07F0, p_c, s_r, o);
    end

    // power-up load
    mem0.m[0] = 16'h0000; mem0.m[1] = 16'h07E0; mem0.m[2] = 16'h00C0; mem0.m[3] = 16'h1000;
    mem1.m[0] = 16'h0000; mem1.m[1] = 16'h07E0; mem1.m[2] = 16'h00C0; mem1.m[3] = 16'h1000;
    run(1, 0, 32'h1234_5678, 32'h0, 16'h8012, 16'h0, -1, -1, 0);
    chk("R8 sp from address 0", spo0, 32'h0000_07E0);
    chk("R8 pc from address 4", pco1, 32'h00C0_1000);
    chk("R8 status", 32'(sro0), 32'h2712);
    chk("R8 stop release with done", 32'(gc[0] & gc[1]), 1);
    chk("R8 no writes", 32'(wn0 + wn1), 0);

    // fault on third frame write
    run(0, 3, 32'h0000_07F0, 32'h00AB_CDEF, 16'h2000, 16'h1111, 2, 2, 0);
    chk("R9 error on write fault (ext)", 32'(ge[0]), 1);
    chk("R9 no done on write fault (basic)", 32'(gd[1]), 0);
    chk("R9 no access after fault (ext)", 32'(cnt0), 3);
    chk("R9 no access after fault (basic)", 32'(cnt1), 3);
    chk("R9 writes before fault", 32'(wn0), 2);

    // fault on the vector fetch
    run(0, 30, 32'h0000_07F0, 32'h0000_0100, 16'h0000, 16'h2222, 4, 3, 0);
    chk("R9 error on fetch fault (ext)", 32'(ge[0]), 1);
    chk("R9 error on fetch fault (basic)", 32'(ge[1]), 1);
    chk("R9 no done on fetch fault", 32'(gd[0] | gd[1]), 0);
    chk("R9 busy low after fault", 32'(busy0 | busy1), 0);

    // extra start while busy
    run(0, 10, 32'h0000_07F0, 32'h0012_3456, 16'h8300, 16'h7777, -1, -1, 1);
    check_vec(10, 32'h0000_07F0, 32'h0012_3456, 16'h8300, 16'h7777);
    chk("R11 no stop release from ignored start", 32'(gc[0] | gc[1]), 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule